// File: doc/BRIEF.md
# Sequenced Radix-2 Time-Decimation Butterfly

This block performs one radix-2 decimation-in-time butterfly on complex operands. Each operand is a 32-bit word that holds a signed 16-bit real half and a signed 16-bit imaginary half. A pulse on the start input captures the operands A and B and a twiddle index k. The block looks up the cosine and sine of 2πk/N in a built-in coefficient table. It multiplies B by the twiddle W = e^(−j2πk/N) and returns (A + W·B)/2 and (A − W·B)/2 in the same packed format.

Work advances through six fixed steps:

1. Operand capture.
2. Table read.
3. Four parallel products.
4. Cross-product truncation and combination.
5. Add/subtract with halving.
6. Packing.

A one-cycle completion strobe marks the result. The results then stay on the outputs until the next completion. A surrounding FFT engine issues one butterfly at a time and owns all addressing. The halving at every stage keeps a log2(N)-stage transform free of growth.

Top module: `dit_butterfly`

## Requirements
- R1: Every sample word carries its real part in bits [31:16] and its imaginary part in bits [15:0], each in 16-bit two's complement. Both inputs and both outputs use this layout.
- R2: The twiddle for index k (0 ≤ k < N/2) has c = round(cos(2πk/N)·32768) and s = round(sin(2πk/N)·32768). Rounding is to the nearest value, with halves going away from zero. Any value above 32767 is clamped to 32767.
- R3: The product W·B is formed as wr = T(Br·c) + T(Bi·s) and wi = T(Bi·c) − T(Br·s). Here T() keeps bits [30:15] of the 32-bit signed product as a signed 16-bit value. wr and wi are exact 17-bit sums.
- R4: The upper output is y0 = (A + W·B) >>> 1 and the lower output is y1 = (A − W·B) >>> 1. Each part is computed exactly and shifted arithmetically, and only its low 16 bits are kept.
- R5: Take the cycle in which an idle block sees start_i high as cycle 0. Then done_o is high in cycle 6 only. In the cycle after that it is low again.
- R6: A start pulse that arrives while an operation is in progress is ignored. It produces no extra completion, and the operands presented with it do not affect the results.
- R7: y0_o and y1_o change only together with a done_o pulse. Between completions they hold their values.
- R8: During and after reset, before any completion, done_o is low and both outputs are zero.
- R9: A start seen in the cycle where done_o is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a butterfly when idle |
| a_i | input | 32 | Operand A, packed {real, imag} |
| b_i | input | 32 | Operand B, packed {real, imag} |
| tw_idx_i | input | KW | Twiddle index k, KW = log2(N/2) |
| done_o | output | 1 | One-cycle completion strobe |
| y0_o | output | 32 | (A + W·B)/2, packed |
| y1_o | output | 32 | (A − W·B)/2, packed |

## Verification
The bench builds the block with its defaults: 16-bit parts and a 16-point table. This leaves only eight twiddle indices, so every index is driven, including W = 1 at k = 0 and W = −j at k = N/4. Each index is paired with full-scale, most-negative, mixed-sign and pseudo-random operands. Those operands push the truncation and wrap paths to their limits. Hand-derived results at k = 0 and k = 4 pin down the table rounding and the halving. Start pulses issued mid-operation and back-to-back starts in the completion cycle cover the sequencing.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned DW_DEF   = 16;
  localparam int unsigned NPTS_DEF = 16;

  typedef enum logic [2:0] {
    STEP_ROM   = 3'd0,
    STEP_MUL   = 3'd1,
    STEP_CROSS = 3'd2,
    STEP_SUM   = 3'd3,
    STEP_PACK  = 3'd4
  } step_e;
endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic cap_en_o,
  output logic rom_en_o,
  output logic mul_en_o,
  output logic cross_en_o,
  output logic sum_en_o,
  output logic pack_en_o
);
  logic  busy_q;
  step_e step_q;

  assign cap_en_o   = start_i && !busy_q;
  assign rom_en_o   = busy_q && (step_q == STEP_ROM);
  assign mul_en_o   = busy_q && (step_q == STEP_MUL);
  assign cross_en_o = busy_q && (step_q == STEP_CROSS);
  assign sum_en_o   = busy_q && (step_q == STEP_SUM);
  assign pack_en_o  = busy_q && (step_q == STEP_PACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= STEP_ROM;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        step_q <= STEP_ROM;
      end
    end else begin
      unique case (step_q)
        STEP_ROM:   step_q <= STEP_MUL;
        STEP_MUL:   step_q <= STEP_CROSS;
        STEP_CROSS: step_q <= STEP_SUM;
        STEP_SUM:   step_q <= STEP_PACK;
        default: begin
          step_q <= STEP_ROM;
          busy_q <= 1'b0;
        end
      endcase
    end
  end

  p_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && step_q == STEP_ROM));
  p_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_q != STEP_PACK) |=> busy_q);
  p_one_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_en_o, mul_en_o, cross_en_o, sum_en_o, pack_en_o}));
  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pack_en_o |=> !busy_q || (step_q == STEP_ROM));
endmodule

// File: rtl/bfly_twiddle_rom.sv
module bfly_twiddle_rom #(
  parameter int unsigned DW   = bfly_pkg::DW_DEF,
  parameter int unsigned NPTS = bfly_pkg::NPTS_DEF,
  localparam int unsigned HALF = NPTS / 2,
  localparam int unsigned KW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [KW-1:0]        idx_i,
  output logic signed [DW-1:0] cos_o,
  output logic signed [DW-1:0] sin_o
);
  localparam real SCALE = 2.0 ** (DW - 1);
  localparam real TWO_PI = 6.283185307179586;

  function automatic logic signed [DW-1:0] to_q(input real v);
    real    sc;
    integer r;
    sc = v * SCALE;
    if (sc >= 0.0) r = $rtoi(sc + 0.5);
    else           r = -$rtoi(-sc + 0.5);
    if (r > (2 ** (DW - 1)) - 1) r = (2 ** (DW - 1)) - 1;
    return DW'(r);
  endfunction

  logic signed [DW-1:0] cos_tab [HALF];
  logic signed [DW-1:0] sin_tab [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_tab
    localparam real ANG = TWO_PI * real'(g) / real'(NPTS);
    assign cos_tab[g] = to_q($cos(ANG));
    assign sin_tab[g] = to_q($sin(ANG));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o <= '0;
      sin_o <= '0;
    end else if (en_i) begin
      cos_o <= cos_tab[idx_i];
      sin_o <= sin_tab[idx_i];
    end
  end
endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
  parameter int unsigned DW = bfly_pkg::DW_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mul_en_i,
  input  logic                 cross_en_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  input  logic signed [DW-1:0] cos_i,
  input  logic signed [DW-1:0] sin_i,
  output logic signed [DW:0]   w_re_o,
  output logic signed [DW:0]   w_im_o
);
  localparam int unsigned PW = 2 * DW;

  // lane order: br*c, bi*s, bi*c, br*s
  logic signed [DW-1:0] op_x [4];
  logic signed [DW-1:0] op_y [4];
  logic signed [PW-1:0] prod_q [4];
  logic signed [DW-1:0] trunc [4];

  assign op_x[0] = b_re_i; assign op_y[0] = cos_i;
  assign op_x[1] = b_im_i; assign op_y[1] = sin_i;
  assign op_x[2] = b_im_i; assign op_y[2] = cos_i;
  assign op_x[3] = b_re_i; assign op_y[3] = sin_i;

  for (genvar g = 0; g < 4; g++) begin : g_mul
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       prod_q[g] <= '0;
      else if (mul_en_i) prod_q[g] <= op_x[g] * op_y[g];
    end
    assign trunc[g] = prod_q[g][PW-2:DW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_re_o <= '0;
      w_im_o <= '0;
    end else if (cross_en_i) begin
      w_re_o <= (DW+1)'(trunc[0]) + (DW+1)'(trunc[1]);
      w_im_o <= (DW+1)'(trunc[2]) - (DW+1)'(trunc[3]);
    end
  end

  p_cross_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cross_en_i |=> (w_re_o <= (DW+1)'(2 ** DW - 2)) && (w_re_o >= -(DW+1)'(2 ** DW)));
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
  parameter int unsigned DW = bfly_pkg::DW_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW:0]   w_re_i,
  input  logic signed [DW:0]   w_im_i,
  output logic signed [DW-1:0] y0_re_o,
  output logic signed [DW-1:0] y0_im_o,
  output logic signed [DW-1:0] y1_re_o,
  output logic signed [DW-1:0] y1_im_o
);
  localparam int unsigned SW = DW + 2;

  logic signed [DW-1:0] a_l  [2];
  logic signed [DW:0]   w_l  [2];
  logic signed [DW-1:0] up_q [2];
  logic signed [DW-1:0] lo_q [2];

  assign a_l[0] = a_re_i; assign w_l[0] = w_re_i;
  assign a_l[1] = a_im_i; assign w_l[1] = w_im_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [SW-1:0] s_up, s_lo;
    assign s_up = SW'(a_l[g]) + SW'(w_l[g]);
    assign s_lo = SW'(a_l[g]) - SW'(w_l[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (en_i) begin
        up_q[g] <= s_up[DW:1];
        lo_q[g] <= s_lo[DW:1];
      end
    end
  end

  assign y0_re_o = up_q[0];
  assign y0_im_o = up_q[1];
  assign y1_re_o = lo_q[0];
  assign y1_im_o = lo_q[1];
endmodule

// File: rtl/dit_butterfly.sv
module dit_butterfly #(
  parameter int unsigned DW   = bfly_pkg::DW_DEF,
  parameter int unsigned NPTS = bfly_pkg::NPTS_DEF,
  localparam int unsigned WW  = 2 * DW,
  localparam int unsigned KW  = (NPTS / 2 > 1) ? $clog2(NPTS / 2) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [WW-1:0] a_i,
  input  logic [WW-1:0] b_i,
  input  logic [KW-1:0] tw_idx_i,
  output logic          done_o,
  output logic [WW-1:0] y0_o,
  output logic [WW-1:0] y1_o
);
  logic cap_en, rom_en, mul_en, cross_en, sum_en, pack_en;
  logic [WW-1:0] a_q, b_q;
  logic [KW-1:0] idx_q;
  logic signed [DW-1:0] cos_w, sin_w;
  logic signed [DW:0]   w_re, w_im;
  logic signed [DW-1:0] y0_re, y0_im, y1_re, y1_im;

  bfly_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cap_en_o   (cap_en),
    .rom_en_o   (rom_en),
    .mul_en_o   (mul_en),
    .cross_en_o (cross_en),
    .sum_en_o   (sum_en),
    .pack_en_o  (pack_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      idx_q <= '0;
    end else if (cap_en) begin
      a_q   <= a_i;
      b_q   <= b_i;
      idx_q <= tw_idx_i;
    end
  end

  bfly_twiddle_rom #(.DW(DW), .NPTS(NPTS)) u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rom_en),
    .idx_i  (idx_q),
    .cos_o  (cos_w),
    .sin_o  (sin_w)
  );

  bfly_cmul #(.DW(DW)) u_cmul (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mul_en_i   (mul_en),
    .cross_en_i (cross_en),
    .b_re_i     (b_q[WW-1:DW]),
    .b_im_i     (b_q[DW-1:0]),
    .cos_i      (cos_w),
    .sin_i      (sin_w),
    .w_re_o     (w_re),
    .w_im_o     (w_im)
  );

  bfly_addsub #(.DW(DW)) u_addsub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sum_en),
    .a_re_i  (a_q[WW-1:DW]),
    .a_im_i  (a_q[DW-1:0]),
    .w_re_i  (w_re),
    .w_im_i  (w_im),
    .y0_re_o (y0_re),
    .y0_im_o (y0_im),
    .y1_re_o (y1_re),
    .y1_im_o (y1_im)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      y0_o   <= '0;
      y1_o   <= '0;
    end else begin
      done_o <= pack_en;
      if (pack_en) begin
        y0_o <= {y0_re, y0_im};
        y1_o <= {y1_re, y1_im};
      end
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(y0_o) && $stable(y1_o)));
  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |=> !done_o);
endmodule

// File: tb/dit_butterfly_tb.sv
module dit_butterfly_tb;
  localparam int DW   = 16;
  localparam int NPTS = 16;
  localparam int KW   = 3;
  localparam time CLK_T = 8ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   a = '0, b = '0;
  logic [KW-1:0] k = '0;
  logic          done;
  logic [31:0]   y0, y1;

  int tests = 0;
  int fails = 0;

  always #(CLK_T/2) clk = ~clk;

  dit_butterfly #(.DW(DW), .NPTS(NPTS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .tw_idx_i(k), .done_o(done), .y0_o(y0), .y1_o(y1)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic int qv(input real v);
    real s;
    int r;
    s = v * 32768.0;
    r = (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
    return (r > 32767) ? 32767 : r;
  endfunction

  function automatic int tr(input longint p);
    logic [15:0] t;
    t = p[30:15];
    return int'($signed(t));
  endfunction

  // R1 R2 R3 R4 reference
  function automatic logic [63:0] model(input logic [31:0] av, input logic [31:0] bv, input int kk);
    int ar, ai, br, bi, c, s, wr, wi;
    logic [15:0] r0, i0, r1, i1;
    real ang;
    ang = 6.283185307179586 * real'(kk) / real'(NPTS);
    c = qv($cos(ang));
    s = qv($sin(ang));
    ar = int'($signed(av[31:16])); ai = int'($signed(av[15:0]));
    br = int'($signed(bv[31:16])); bi = int'($signed(bv[15:0]));
    wr = tr(longint'(br) * c) + tr(longint'(bi) * s);
    wi = tr(longint'(bi) * c) - tr(longint'(br) * s);
    r0 = 16'((ar + wr) >>> 1); i0 = 16'((ai + wi) >>> 1);
    r1 = 16'((ar - wr) >>> 1); i1 = 16'((ai - wi) >>> 1);
    return {r0, i0, r1, i1};
  endfunction

  // drive at negedge, count cycles to done (start cycle = 0)
  task automatic run_op(input logic [31:0] av, input logic [31:0] bv, input int kk, output int lat);
    start = 1'b1; a = av; b = bv; k = KW'(kk);
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic op_check(input logic [31:0] av, input logic [31:0] bv, input int kk);
    int lat;
    logic [63:0] e;
    e = model(av, bv, kk);
    run_op(av, bv, kk, lat);
    chk("R5 latency", 32'(lat), 32'd6);
    chk("R4 y0", y0, e[63:32]);
    chk("R4 y1", y1, e[31:0]);
    @(negedge clk);
    chk("R5 pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(CLK_T * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] pa [6];
    logic [31:0] pb [6];
    logic [31:0] lf;
    logic [31:0] h0, h1;
    int lat, dcnt;
    pa[0] = 32'h0000_0000; pb[0] = 32'h0000_0000;
    pa[1] = 32'h7FFF_7FFF; pb[1] = 32'h7FFF_7FFF;
    pa[2] = 32'h8000_8000; pb[2] = 32'h8000_8000;
    pa[3] = 32'h7FFF_8000; pb[3] = 32'h8000_7FFF;
    pa[4] = 32'h1234_EDCB; pb[4] = 32'hC000_4000;
    pa[5] = 32'hFFFF_0001; pb[5] = 32'h0001_FFFF;
    lf = 32'hACE1_2468;

    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 y0", y0, '0);
    chk("R8 y1", y1, '0);
    chk("R8 done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 done after release", {31'd0, done}, 32'd0);

    // R2 R4 hand values: W=1 and W=-j, B=16384, A=0
    run_op(32'h0, 32'h4000_0000, 0, lat);
    chk("R2 k0 y0", y0, {16'd8191, 16'd0});
    chk("R2 k0 y1", y1, {-16'sd8192, 16'd0});
    @(negedge clk);
    run_op(32'h0, 32'h4000_0000, NPTS/4, lat);
    chk("R3 kN4 y0", y0, {16'd0, -16'sd8192});
    chk("R3 kN4 y1", y1, {16'd0, 16'd8191});
    @(negedge clk);

    // R1 R3 R4 sweep over all twiddles
    for (int kk = 0; kk < NPTS/2; kk++) begin
      for (int p = 0; p < 6; p++) op_check(pa[p], pb[p], kk);
      for (int p = 0; p < 4; p++) begin
        logic [31:0] ra, rb;
        lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; ra = lf;
        lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5; rb = lf;
        op_check(ra, rb, kk);
      end
    end

    // R6 start while busy ignored; R7 hold
    begin
      logic [63:0] e;
      e = model(32'h1000_2000, 32'h3000_C000, 3);
      start = 1'b1; a = 32'h1000_2000; b = 32'h3000_C000; k = 3'd3;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; a = 32'h7FFF_7FFF; b = 32'h8000_8000; k = 3'd5;
      @(negedge clk);
      start = 1'b0;
      dcnt = 0;
      for (int i = 0; i < 14; i++) begin
        if (done) begin
          dcnt++;
          h0 = y0; h1 = y1;
        end
        @(negedge clk);
      end
      chk("R6 single done", 32'(dcnt), 32'd1);
      chk("R6 y0 unaffected", h0, e[63:32]);
      chk("R6 y1 unaffected", h1, e[31:0]);
      chk("R7 y0 held", y0, e[63:32]);
      chk("R7 y1 held", y1, e[31:0]);
    end

    // R9 back-to-back start in the done cycle
    begin
      logic [63:0] e;
      run_op(32'h0100_0200, 32'h0300_0400, 1, lat);
      e = model(32'h0500_0600, 32'h0700_0800, 2);
      run_op(32'h0500_0600, 32'h0700_0800, 2, lat);
      chk("R9 latency", 32'(lat), 32'd6);
      chk("R9 y0", y0, e[63:32]);
      chk("R9 y1", y1, e[31:0]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule